// File: doc/BRIEF.md
# Drift-Absorbing Elastic Word Buffer

This block carries 16-bit parallel words from an external input clock into the internal word clock. It absorbs slow phase wander between the two clocks in an eight-entry store. The write side counts input clock cycles in Gray code. The read side synchronizes that count, turns it back into a word pointer, and keeps its own read pointer about half the store behind it. A two-bit mode input selects the write clock rate. At full rate the input clock runs at the word rate and one word is taken on each rising edge. At half rate it runs at half the word rate and two words, `in_first` then `in_second`, are taken on each rising edge.

Recentering moves the read pointer so that it sits four words behind the observed write pointer. Three events cause it: lock being acquired (the active-low lost-lock input rising), the end of a long enough external realign request, and a fixed sequence that follows an overflow alarm. After each recenter, `data_ok` stays low for a programmable settling count, so that downstream logic ignores words while the clocks settle.

Top module: `elastic_word_buffer`

## Requirements
- R1: While `rst` is high and after it is released, `data_ok` and `slip_alarm` are 0 until a recenter has taken place.
- R2: In full-rate mode (`clk_mode` = 2'b00), `in_first` is captured on every rising edge of `in_clk`. While `data_ok` is high, consecutive output words are consecutive captured words, with none lost and none repeated.
- R3: In half-rate mode (`clk_mode` = 2'b10), `in_first` and then `in_second` are captured on every rising edge of `in_clk`. While `data_ok` is high, the output follows that word order with none lost and none repeated.
- R4: While `lock_lost_n` is low, `data_ok` and `slip_alarm` are 0. At the first `core_clk` edge that samples `lock_lost_n` high after it was low, the read pointer is recentered, and `data_ok` stays low until SETTLE_CYC edges later, where it rises.
- R5: If `realign_req` is high for 4 or more consecutive `core_clk` edges, the buffer recenters at the first edge that samples it low, and `data_ok` drops there and rises SETTLE_CYC edges later. A pulse shorter than 4 edges has no effect: `data_ok` stays high and the word order continues.
- R6: The observed separation is the write word pointer minus the read pointer, modulo 16. When it equals 0 or is 8 or more, `slip_alarm` goes high for exactly 4 `core_clk` cycles, and `data_ok` goes low on the same edge.
- R7: The overflow recenter happens 3 cycles after `slip_alarm` falls, which is 7 cycles after it rose. `data_ok` then rises SETTLE_CYC edges after that recenter.
- R8: Between the rise of `slip_alarm` and its recenter, no second alarm can start. After that recenter the word order is intact again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| core_clk | input | 1 | Internal word clock (read side) |
| rst | input | 1 | Synchronous active-high reset, core domain |
| in_clk | input | 1 | External parallel input clock (write side) |
| clk_mode | input | 2 | 00 = full-rate input clock, 10 = half-rate input clock |
| lock_lost_n | input | 1 | Low while the PLL is out of lock |
| realign_req | input | 1 | Active-high external recenter request |
| in_first | input | 16 | Input word; the earlier word of the pair at half rate |
| in_second | input | 16 | Later word of the pair, used at half rate only |
| out_word | output | 16 | Word read in the core domain |
| data_ok | output | 1 | High when `out_word` is reliable |
| slip_alarm | output | 1 | Overflow indication |

## Verification
A counting word stream is fed at full rate and at half rate with both clocks at equal speed. The word order is checked on every valid cycle, which separates a correct pair order and bank split from lost, repeated or swapped words. Realign pulses of 3 and 4 edges distinguish the length threshold. A write clock running 5% slow and 5% fast drives the separation to each edge of the window. For each, the alarm width and the exact cycle at which `data_ok` returns show where the recenter happened.

// File: rtl/eb_pkg.sv
package eb_pkg;
  localparam logic [1:0] MODE_FULL = 2'b00;
  localparam logic [1:0] MODE_HALF = 2'b10;

  function automatic logic is_half(input logic [1:0] m);
    return m == MODE_HALF;
  endfunction
endpackage

// File: rtl/eb_wr_side.sv
module eb_wr_side #(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic                   in_clk,
  input  logic                   rst,
  input  logic [1:0]             clk_mode,
  input  logic [DW-1:0]          in_first,
  input  logic [DW-1:0]          in_second,
  output logic [1:0]             wr_en,
  output logic [AW-2:0]          wr_idx,
  output logic [1:0][DW-1:0]     wr_dat,
  output logic [AW:0]            wr_gray
);
  localparam int PW = AW + 1;

  logic          rs1, rs2;
  logic [PW-1:0] wbin, wbin_nx;
  logic          half;

  assign half    = eb_pkg::is_half(clk_mode);
  assign wbin_nx = wbin + 1'b1;

  // reset brought into the input clock domain
  always_ff @(posedge in_clk) begin
    rs1 <= rst;
    rs2 <= rs1;
  end

  // cycle counter, kept in binary and in Gray form
  always_ff @(posedge in_clk) begin
    if (rs2) begin
      wbin    <= '0;
      wr_gray <= '0;
    end else begin
      wbin    <= wbin_nx;
      wr_gray <= wbin_nx ^ (wbin_nx >> 1);
    end
  end

  // even words go to bank 0, odd words to bank 1
  always_comb begin
    wr_en[0]  = !rs2 && (half || !wbin[0]);
    wr_en[1]  = !rs2 && (half ||  wbin[0]);
    wr_idx    = half ? wbin[AW-2:0] : wbin[AW-1:1];
    wr_dat[0] = in_first;
    wr_dat[1] = half ? in_second : in_first;
  end
endmodule

// File: rtl/eb_word_store.sv
module eb_word_store #(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic               wr_clk,
  input  logic [1:0]         wr_en,
  input  logic [AW-2:0]      wr_idx,
  input  logic [1:0][DW-1:0] wr_dat,
  input  logic               rd_clk,
  input  logic               rd_en,
  input  logic [AW:0]        rd_addr,
  output logic [DW-1:0]      rd_data
);
  localparam int BANK_D = 1 << (AW - 1);

  logic [1:0][DW-1:0] bank_q;
  logic               sel_q;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DW-1:0] mem [BANK_D];
    logic [DW-1:0] q;

    always_ff @(posedge wr_clk) begin
      if (wr_en[b]) mem[wr_idx] <= wr_dat[b];
    end

    always_ff @(posedge rd_clk) begin
      if (rd_en) q <= mem[rd_addr[AW-1:1]];
    end

    assign bank_q[b] = q;
  end

  always_ff @(posedge rd_clk) begin
    if (rd_en) sel_q <= rd_addr[0];
  end

  assign rd_data = bank_q[sel_q];
endmodule

// File: rtl/eb_rd_ctrl.sv
module eb_rd_ctrl #(
  parameter int AW         = 3,
  parameter int SETTLE_CYC = 1250,
  parameter int OVF_HI     = 4,
  parameter int OVF_GAP    = 3,
  parameter int HOLD_MIN   = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    clk_mode,
  input  logic          lock_lost_n,
  input  logic          realign_req,
  input  logic [AW:0]   wr_gray,
  output logic [AW:0]   rptr,
  output logic          data_ok,
  output logic          slip_alarm
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam int SEQ_N = OVF_HI + OVF_GAP;
  localparam int SQW   = $clog2(SEQ_N + 1);
  localparam int SCW   = $clog2(SETTLE_CYC + 1);
  localparam int HW    = $clog2(HOLD_MIN + 1);

  logic [PW-1:0]  ws1, ws2, wb, wword, sep;
  logic           lock_q, req_q;
  logic [HW-1:0]  hold_cnt;
  logic [SQW-1:0] seq_cnt, seq_nx;
  logic [SCW-1:0] settle_cnt;
  logic           sep_bad, lock_rise, req_end, seq_end, recenter, start_ovf;

  always_comb begin
    wb[PW-1] = ws2[PW-1];
    for (int i = PW - 2; i >= 0; i--) wb[i] = wb[i+1] ^ ws2[i];
  end

  assign wword     = eb_pkg::is_half(clk_mode) ? {wb[PW-2:0], 1'b0} : wb;
  assign sep       = wword - rptr;
  assign sep_bad   = (sep == '0) || (sep >= PW'(DEPTH));
  assign lock_rise = lock_lost_n && !lock_q;
  assign req_end   = !realign_req && req_q && (hold_cnt >= HW'(HOLD_MIN));
  assign seq_end   = (seq_cnt == SQW'(SEQ_N));
  assign recenter  = lock_rise || (lock_lost_n && (req_end || seq_end));
  assign start_ovf = lock_lost_n && lock_q && (seq_cnt == '0) && sep_bad && !recenter;

  always_comb begin
    if (start_ovf)            seq_nx = SQW'(1);
    else if (seq_end)         seq_nx = '0;
    else if (seq_cnt != '0)   seq_nx = seq_cnt + 1'b1;
    else                      seq_nx = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ws1        <= '0;
      ws2        <= '0;
      lock_q     <= 1'b0;
      req_q      <= 1'b0;
      hold_cnt   <= '0;
      seq_cnt    <= '0;
      settle_cnt <= '0;
      rptr       <= '0;
      data_ok    <= 1'b0;
      slip_alarm <= 1'b0;
    end else begin
      ws1    <= wr_gray;
      ws2    <= ws1;
      lock_q <= lock_lost_n;
      req_q  <= realign_req;
      if (!realign_req)                   hold_cnt <= '0;
      else if (hold_cnt != HW'(HOLD_MIN)) hold_cnt <= hold_cnt + 1'b1;

      if (!lock_lost_n) begin
        seq_cnt    <= '0;
        settle_cnt <= '0;
        data_ok    <= 1'b0;
        slip_alarm <= 1'b0;
      end else begin
        seq_cnt    <= seq_nx;
        slip_alarm <= (seq_nx != '0) && (seq_nx <= SQW'(OVF_HI));
        rptr       <= recenter ? wword - PW'(DEPTH / 2) : rptr + 1'b1;
        if (recenter)                settle_cnt <= SCW'(SETTLE_CYC);
        else if (settle_cnt != '0)   settle_cnt <= settle_cnt - 1'b1;
        if (recenter || start_ovf)   data_ok <= 1'b0;
        else if (settle_cnt == SCW'(1) && seq_nx == '0) data_ok <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/elastic_word_buffer.sv
module elastic_word_buffer #(
  parameter int DW         = 16,
  parameter int AW         = 3,
  parameter int SETTLE_CYC = 1250
) (
  input  logic          core_clk,
  input  logic          rst,
  input  logic          in_clk,
  input  logic [1:0]    clk_mode,
  input  logic          lock_lost_n,
  input  logic          realign_req,
  input  logic [15:0]   in_first,
  input  logic [15:0]   in_second,
  output logic [15:0]   out_word,
  output logic          data_ok,
  output logic          slip_alarm
);
  logic [1:0]         wr_en;
  logic [AW-2:0]      wr_idx;
  logic [1:0][DW-1:0] wr_dat;
  logic [AW:0]        wr_gray;
  logic [AW:0]        rptr;

  eb_wr_side #(.DW(DW), .AW(AW)) u_wr (
    .in_clk    (in_clk),
    .rst       (rst),
    .clk_mode  (clk_mode),
    .in_first  (in_first),
    .in_second (in_second),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_dat    (wr_dat),
    .wr_gray   (wr_gray)
  );

  eb_word_store #(.DW(DW), .AW(AW)) u_store (
    .wr_clk  (in_clk),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_dat  (wr_dat),
    .rd_clk  (core_clk),
    .rd_en   (lock_lost_n),
    .rd_addr (rptr),
    .rd_data (out_word)
  );

  eb_rd_ctrl #(.AW(AW), .SETTLE_CYC(SETTLE_CYC)) u_ctrl (
    .clk         (core_clk),
    .rst         (rst),
    .clk_mode    (clk_mode),
    .lock_lost_n (lock_lost_n),
    .realign_req (realign_req),
    .wr_gray     (wr_gray),
    .rptr        (rptr),
    .data_ok     (data_ok),
    .slip_alarm  (slip_alarm)
  );
endmodule

// File: rtl/eb_checker.sv
module eb_checker (
  input logic core_clk,
  input logic rst,
  input logic lock_lost_n,
  input logic data_ok,
  input logic slip_alarm
);
  assert_unlocked_invalid_R4: assert property (@(posedge core_clk) disable iff (rst)
    !lock_lost_n |=> !data_ok);

  assert_lock_edge_invalid_R4: assert property (@(posedge core_clk) disable iff (rst)
    $rose(lock_lost_n) |=> !data_ok);

  assert_alarm_width_R6: assert property (@(posedge core_clk) disable iff (rst || !lock_lost_n)
    $rose(slip_alarm) |=> slip_alarm ##1 slip_alarm ##1 slip_alarm ##1 !slip_alarm);

  assert_alarm_blocks_valid_R6: assert property (@(posedge core_clk) disable iff (rst)
    slip_alarm |-> !data_ok);

  assert_no_retrigger_R8: assert property (@(posedge core_clk) disable iff (rst || !lock_lost_n)
    $fell(slip_alarm) |=> !slip_alarm ##1 !slip_alarm ##1 !slip_alarm);

  assert_invalid_before_recenter_R7: assert property (@(posedge core_clk) disable iff (rst)
    $fell(slip_alarm) |-> !data_ok);
endmodule

bind elastic_word_buffer eb_checker u_chk (
  .core_clk    (core_clk),
  .rst         (rst),
  .lock_lost_n (lock_lost_n),
  .data_ok     (data_ok),
  .slip_alarm  (slip_alarm)
);

// File: tb/sim_elastic_word_buffer.sv
module sim_elastic_word_buffer;
  localparam int S = 32;

  logic        core_clk = 1'b0;
  logic        in_clk   = 1'b0;
  logic        rst      = 1'b1;
  logic [1:0]  clk_mode = 2'b00;
  logic        lock_lost_n = 1'b0;
  logic        realign_req = 1'b0;
  logic [15:0] in_first  = '0;
  logic [15:0] in_second = '0;
  logic [15:0] out_word;
  logic        data_ok, slip_alarm;

  int unsigned in_half_ps = 10000;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;

  elastic_word_buffer #(.SETTLE_CYC(S)) u0 (
    .core_clk (core_clk), .rst (rst), .in_clk (in_clk), .clk_mode (clk_mode),
    .lock_lost_n (lock_lost_n), .realign_req (realign_req),
    .in_first (in_first), .in_second (in_second),
    .out_word (out_word), .data_ok (data_ok), .slip_alarm (slip_alarm)
  );

  initial forever #10ns core_clk = ~core_clk;

  initial begin
    #7ns;
    forever begin
      in_clk = 1'b1; #(in_half_ps * 1ps);
      in_clk = 1'b0; #(in_half_ps * 1ps);
    end
  end

  // counting word source, changed away from the capturing edge
  initial begin
    logic [15:0] m;
    m = '0;
    forever begin
      @(negedge in_clk);
      if (clk_mode == 2'b10) begin
        in_first  = 16'(2 * m);
        in_second = 16'(2 * m + 1);
      end else begin
        in_first  = m;
        in_second = '0;
      end
      m = m + 1'b1;
    end
  end

  task automatic step();
    @(posedge core_clk);
    @(negedge core_clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_order(input int n, input string req, input bit keep_valid);
    bit          pv;
    logic [15:0] pw;
    pv = 1'b0;
    pw = '0;
    for (int i = 0; i < n; i++) begin
      step();
      if (keep_valid) check(data_ok == 1'b1, req, int'(data_ok), 1);
      check(slip_alarm == 1'b0, req, int'(slip_alarm), 0);
      if (data_ok && pv) check(out_word == pw + 16'd1, req, int'(out_word), int'(pw + 16'd1));
      pv = data_ok;
      pw = out_word;
    end
  endtask

  task automatic expect_settle(input string req);
    for (int i = 0; i <= S; i++) begin
      if (i > 0) step();
      if (i == 0 || i == S - 1) check(data_ok == 1'b0, req, int'(data_ok), 0);
      if (i == S)               check(data_ok == 1'b1, req, int'(data_ok), 1);
    end
  endtask

  task automatic relock(input logic [1:0] mode, input int unsigned half_ps);
    lock_lost_n = 1'b0;
    clk_mode    = mode;
    in_half_ps  = half_ps;
    repeat (6) step();
    check(data_ok == 1'b0, "R4", int'(data_ok), 0);
    check(slip_alarm == 1'b0, "R4", int'(slip_alarm), 0);
    lock_lost_n = 1'b1;
    step();
    expect_settle("R4");
  endtask

  task automatic alarm_case(input string req, input bit post_order);
    int wait_n;
    wait_n = 0;
    while (slip_alarm == 1'b0 && wait_n < 3000) begin
      step();
      wait_n++;
    end
    check(slip_alarm == 1'b1, "R6", int'(slip_alarm), 1);
    check(data_ok == 1'b0, "R6", int'(data_ok), 0);
    for (int i = 1; i <= 7 + S; i++) begin
      step();
      if (i <= 3)          check(slip_alarm == 1'b1, "R6", int'(slip_alarm), 1);
      else if (i <= 7)     check(slip_alarm == 1'b0, "R8", int'(slip_alarm), 0);
      if (i == 7 + S - 1)  check(data_ok == 1'b0, req, int'(data_ok), 0);
      if (i == 7 + S)      check(data_ok == 1'b1, req, int'(data_ok), 1);
    end
    if (post_order) run_order(10, "R8", 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge core_clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (5) step();
    check(data_ok == 1'b0, "R1", int'(data_ok), 0);
    check(slip_alarm == 1'b0, "R1", int'(slip_alarm), 0);
    rst = 1'b0;
    repeat (8) step();
    check(data_ok == 1'b0, "R1", int'(data_ok), 0);
    check(slip_alarm == 1'b0, "R1", int'(slip_alarm), 0);

    // R2: full rate, equal clocks
    relock(2'b00, 10000);
    run_order(120, "R2", 1'b1);

    // R5: 3-edge pulse ignored, 4-edge pulse recenters
    realign_req = 1'b1;
    repeat (3) step();
    realign_req = 1'b0;
    run_order(20, "R5", 1'b1);
    realign_req = 1'b1;
    repeat (4) step();
    realign_req = 1'b0;
    step();
    expect_settle("R5");
    run_order(20, "R5", 1'b1);

    // R3: half rate, input clock at half the word rate
    relock(2'b10, 20000);
    run_order(150, "R3", 1'b1);

    // R6/R7: slow writer reaches the lower window edge
    relock(2'b00, 10500);
    alarm_case("R7", 1'b1);

    // R6/R7: fast writer reaches the upper window edge
    relock(2'b00, 9500);
    alarm_case("R7", 1'b0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule